// File: doc/BRIEF.md
# Iterative Population Counter

This block counts the set bits of a data word one bit per step, using a small controller that sequences a datapath of two registers: a right shifter loaded in parallel and a bit counter with a synchronous clear. A start request captures a word and clears the counter. The loop then adds the low bit of the word to the counter and shifts the word right. It stops as soon as the bits still to be examined are all zero, so a word with few high-order bits finishes early.

When the loop ends, the count appears on the result port for exactly one cycle, marked by a valid flag, and the controller returns to idle. Outside that cycle the result port reads zero. A parameter picks one of two controllers. The first takes two states per bit, and every register load in it is unconditional. The second takes one state per bit and gates the counter load with the low bit. Both give the same count for every word. Start requests are taken only while idle.

Top module: `popc_fsmd`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `valid` is 0 and `result` is 0. After reset is released, no run is in progress, including when reset arrived in the middle of a run.
- R2: When idle with `start` low, the block stays idle: `valid` stays 0. A high `start` sampled at a rising edge while idle begins a run.
- R3: The word on `din` is sampled at the rising edge one cycle after the edge that accepted `start`. When `valid` is 1, `result` equals the number of 1 bits in that word, zero-extended to `DATA_W` bits. This holds for both controller variants.
- R4: A word of zero gives a result of 0, and a word of all ones gives a result of `DATA_W`. The internal count never exceeds `DATA_W`.
- R5: `valid` is high for exactly one cycle per run. The controller then returns to idle whatever `start` is.
- R6: When `valid` is 0, `result` is 0.
- R7: While a run is in progress, `start` pulses and changes on `din` after the capture edge have no effect on the result or on the latency of that run.
- R8: With `MEALY = 0`, let n be the 1-based index of the highest set bit of the word, or 1 for a zero word. `valid` rises 2n+1 rising edges after the edge that accepted `start`.
- R9: With `MEALY = 1`, `valid` rises n+1 rising edges after the accepting edge, with n defined as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, sampled only while idle |
| din | input | DATA_W | Word to be counted, captured one cycle after start is accepted |
| result | output | DATA_W | Bit count while valid, zero otherwise |
| valid | output | 1 | High for one cycle when the count is ready |

## Verification
The assertions assume two things. First, reset is released only between clock edges. Second, `din` is stable at the capture edge that follows an accepted `start`; nothing is assumed about `start` or `din` at any other time. The bench drives every input at the falling edge and holds `din` through the capture edge. After that edge it scrambles `din` with `$urandom` values and may raise `start` while the run is still going. The assertions on the shifter, the count bound and the stopping condition must therefore hold under arbitrary input activity during a run. Both controller variants are instantiated side by side and fed identical stimulus.

// File: rtl/popc_pkg.sv
`timescale 1ns/1ps
package popc_pkg;

  // Controller states; the one-state-per-bit controller uses a subset.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ADD   = 3'd2,
    ST_SHIFT = 3'd3,
    ST_RUN   = 3'd4,
    ST_DONE  = 3'd5
  } popc_state_e;

endpackage

// File: rtl/popc_datapath.sv
`timescale 1ns/1ps
module popc_datapath #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              load,
  input  logic              acc,
  input  logic              shift,
  input  logic              oe,
  output logic              lsb,
  output logic              rest_zero,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              word_en, cnt_en;

  assign word_en = load | shift;
  assign cnt_en  = load | acc;

  // Shifter with parallel load
  always_comb begin
    word_d = word_q;
    if (load)       word_d = din;
    else if (shift) word_d = word_q >> 1;
  end

  // Counter with synchronous clear; adds the current low bit
  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = '0;
    else if (acc) cnt_d = cnt_q + CNT_W'(word_q[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (word_en) word_q <= word_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  // Status back to the controller
  assign lsb       = word_q[0];
  assign rest_zero = ((word_q >> 1) == '0);

  // Output enable: count only in the done state
  assign result = oe ? DATA_W'(cnt_q) : '0;

  // R4: count stays within the word width
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DATA_W));

  // R3: a shift drops exactly the low bit's worth of ones
  p_shift_drops_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (int'($countones(word_q)) + int'($past(word_q[0]))
                          == int'($countones($past(word_q)))));

endmodule

// File: rtl/popc_ctrl_moore.sv
`timescale 1ns/1ps
module popc_ctrl_moore
  import popc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lsb,
  input  logic rest_zero,
  output logic load,
  output logic acc,
  output logic shift,
  output logic oe,
  output logic done
);

  popc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_ADD;
      ST_ADD:   state_d = ST_SHIFT;
      ST_SHIFT: state_d = rest_zero ? ST_DONE : ST_ADD;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Outputs depend on the state only
  assign load  = (state_q == ST_LOAD);
  assign acc   = (state_q == ST_ADD);
  assign shift = (state_q == ST_SHIFT);
  assign done  = (state_q == ST_DONE);
  assign oe    = done;

  // R2: idle without a request never produces done
  p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> !done);

  // R3: done only once the datapath word is empty
  p_done_after_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rest_zero && !lsb));

endmodule

// File: rtl/popc_ctrl_mealy.sv
`timescale 1ns/1ps
module popc_ctrl_mealy
  import popc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lsb,
  input  logic rest_zero,
  output logic load,
  output logic acc,
  output logic shift,
  output logic oe,
  output logic done
);

  popc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_RUN;
      ST_RUN:  state_d = rest_zero ? ST_DONE : ST_RUN;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  logic running;
  assign running = (state_q == ST_RUN);

  // Counter load gated by the low bit; shift every loop cycle
  assign load  = (state_q == ST_LOAD);
  assign acc   = running & lsb;
  assign shift = running;
  assign done  = (state_q == ST_DONE);
  assign oe    = done;

  // R2: idle without a request never produces done
  p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> !done);

  // R3: done only once the datapath word is empty
  p_done_after_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rest_zero && !lsb));

endmodule

// File: rtl/popc_fsmd.sv
`timescale 1ns/1ps
module popc_fsmd #(
  parameter int DATA_W = 8,
  parameter int MEALY  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] result,
  output logic              valid
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic load, acc, shift, oe, done, lsb, rest_zero;

  generate
    if (MEALY != 0) begin : g_mealy
      popc_ctrl_mealy u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .lsb(lsb),
        .rest_zero(rest_zero), .load(load), .acc(acc), .shift(shift),
        .oe(oe), .done(done));
    end else begin : g_moore
      popc_ctrl_moore u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .lsb(lsb),
        .rest_zero(rest_zero), .load(load), .acc(acc), .shift(shift),
        .oe(oe), .done(done));
    end
  endgenerate

  popc_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .din(din), .load(load), .acc(acc),
    .shift(shift), .oe(oe), .lsb(lsb), .rest_zero(rest_zero),
    .result(result));

  assign valid = done;

  // R5: valid is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R6: result reads zero outside the valid cycle
  p_result_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (result == '0));

endmodule

// File: tb/popc_fsmd_bench.sv
`timescale 1ns/1ps
module popc_fsmd_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] res_mo, res_me;
  logic         vld_mo, vld_me;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  popc_fsmd #(.DATA_W(W), .MEALY(0)) u_popc_fsmd (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .result(res_mo), .valid(vld_mo));

  popc_fsmd #(.DATA_W(W), .MEALY(1)) u_popc_fsmd_mealy (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .result(res_me), .valid(vld_me));

  function automatic int ref_ones(logic [W-1:0] v);
    int s = 0;
    for (int i = 0; i < W; i++) s += int'(v[i]);
    return s;
  endfunction

  function automatic int ref_iters(logic [W-1:0] v);
    int h = 0;
    for (int i = 0; i < W; i++) if (v[i]) h = i + 1;
    return (h == 0) ? 1 : h;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One run on both variants; disturb scrambles din and pulses start while busy (R7)
  task automatic run_one(logic [W-1:0] v, bit disturb);
    int lm = 2 * ref_iters(v) + 1;
    int le = ref_iters(v) + 1;
    int pc = ref_ones(v);
    int got_mo = -1;
    int got_me = -1;
    string rq = (v == '0 || v == '1) ? "R4" : "R3";
    @(negedge clk);
    start = 1'b1;
    din   = v;
    @(negedge clk);       // start accepted; din held through the capture edge
    start = 1'b0;
    for (int c = 1; c <= lm + 2; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (vld_mo && got_mo < 0) got_mo = c;
      if (vld_me && got_me < 0) got_me = c;
      if (vld_mo) check(res_mo == W'(pc), rq, "moore count", int'(res_mo), pc);
      else        check(res_mo == '0, "R6", "moore idle result", int'(res_mo), 0);
      if (vld_me) check(res_me == W'(pc), rq, "mealy count", int'(res_me), pc);
      else        check(res_me == '0, "R6", "mealy idle result", int'(res_me), 0);
      if (got_mo > 0 && c == got_mo + 1) check(!vld_mo, "R5", "moore pulse", int'(vld_mo), 0);
      if (got_me > 0 && c == got_me + 1) check(!vld_me, "R5", "mealy pulse", int'(vld_me), 0);
      if (disturb) begin
        din   = W'($urandom);
        start = (c + 1 >= 2 && c + 1 <= le - 1) ? 1'($urandom % 2) : 1'b0;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(got_mo == lm, "R8", "moore latency", got_mo, lm);
    check(got_me == le, "R9", "mealy latency", got_me, le);
    if (disturb) check(got_mo == lm && got_me == le, "R7", "latency under busy start", got_me, le);
  endtask

  task automatic idle_hold(int cycles, string req);
    start = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(!vld_mo && !vld_me, req, "idle valid", int'(vld_mo) + int'(vld_me), 0);
      check(res_mo == '0 && res_me == '0, req, "idle result", int'(res_mo | res_me), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: outputs under reset
    #5;
    check(!vld_mo && !vld_me, "R1", "valid in reset", int'(vld_mo) + int'(vld_me), 0);
    check(res_mo == '0 && res_me == '0, "R1", "result in reset", int'(res_mo | res_me), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R2: no request, nothing happens
    idle_hold(6, "R2");

    // Directed corners, R4
    run_one('0, 1'b0);
    run_one('1, 1'b0);
    run_one(W'(1) << (W - 1), 1'b1);
    run_one(W'(1), 1'b1);

    // Exhaustive sweep with busy-time disturbance, R3 and R7
    for (int v = 0; v < (1 << W); v++) run_one(W'(v), 1'b1);

    // Constrained random words
    for (int k = 0; k < 40; k++) run_one(W'($urandom), 1'b1);

    // R1: reset in the middle of a run
    @(negedge clk);
    start = 1'b1;
    din   = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check(!vld_mo && !vld_me, "R1", "valid on mid-run reset", int'(vld_mo) + int'(vld_me), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_hold(25, "R1");
    run_one(W'(8'h5A), 1'b0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule